// File: doc/BRIEF.md
# Double-Buffered Timer PWM Generator

This block drives a single pulse-width-modulated output from an 8-bit timer. The timer counts up to a programmable period value and then restarts at zero. Each input clock is one quarter of an instruction cycle. The timer steps once per instruction cycle, divided further by a selectable prescale of 1, 4 or 16. The pulse width is a 10-bit value supplied as an 8-bit upper part and a 2-bit lower part. It is compared against the timer extended by two fine bits, so the edge can be placed with sub-step precision.

The written pulse width is copied into a shadow register only when the timer wraps. A new value can be applied at any time, and a running period is never cut short or stretched by a change in the middle of the period. At each wrap the output goes high, unless the newly captured width is zero. The output goes low when the extended timer reaches the shadow width. If the width is larger than the period, that compare never matches and the output stays high.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: While `rst_n` is low or `en` is low, `pwm_o` is low one clock later, and the timer, prescaler and phase counters are held at zero. Resetting also clears the shadow width to zero.
- R2: Prescale select `psel_i` encodes 2'b00 = divide by 1, 2'b01 = divide by 4, and 2'b10 or 2'b11 = divide by 16. One output period lasts (period_i + 1) × 4 × prescale clocks.
- R3: On the timer step where the timer equals `period_i`, the timer returns to zero, the shadow width loads {duty_hi_i, duty_lo_i}, and `pwm_o` is set high. Setting the output happens nowhere else.
- R4: After a wrap, `pwm_o` falls on the first clock where the next-state value {timer, fine} equals the shadow width. The fine bits are the quarter-cycle phase at divide by 1, and the low 2 prescaler bits otherwise. The high time is therefore duty clocks (÷1), duty × 4 clocks (÷4), or (duty>>2) × 64 + (duty & 3) × 4 clocks (÷16).
- R5: A captured width of zero keeps `pwm_o` low for the whole period.
- R6: A width at or beyond the period length (no reachable compare value) keeps `pwm_o` high for the whole period.
- R7: Writes to `duty_hi_i`/`duty_lo_i` in the middle of a period do not change that period's high time. They take effect from the next wrap onward.
- R8: If a wrap and a clear compare occur on the same clock, the set wins and `pwm_o` goes high.
- R9: After `en` rises, `pwm_o` stays low until the first wrap, because counting starts from zero and the set happens only at a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; four clocks make one instruction cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds the counters at zero and the output low |
| period_i | input | 8 | Terminal timer count |
| duty_hi_i | input | 8 | Upper 8 bits of the pulse width |
| duty_lo_i | input | 2 | Lower 2 bits of the pulse width |
| psel_i | input | 2 | Prescale select (00 ÷1, 01 ÷4, 1x ÷16) |
| pwm_o | output | 1 | Registered PWM output |

## Verification
Each setting is measured over one full period that starts at the first wrap after enable. The clocks where the output is high are counted and compared with the high-time formula for that prescale.

The settings are chosen to separate distinct behaviours:
- An odd width at divide by 1 exposes the phase-based fine bits.
- Settings at divide by 4 and divide by 16 show whether the prescaler bits, rather than the phase, feed the compare.
- A zero width and an oversize width cover the set-suppression path and the never-matching compare.
- A minimal one-step period and a full 255 period with width 1023 cover the boundaries of the range.

A width changed in the middle of a period separates true double buffering from a direct compare. The first period after power-up, which has a zero shadow width and a live new width at the wrap, shows whether set beats clear.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

    localparam int TMR_W  = 8;
    localparam int FINE_W = 2;
    localparam int PRE_W  = 4;
    localparam int DUTY_W = TMR_W + FINE_W;

    typedef enum logic [1:0] {
        PS_DIV1  = 2'b00,
        PS_DIV4  = 2'b01,
        PS_DIV16 = 2'b10,
        PS_DIV16B = 2'b11
    } psel_e;

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_dbuf_pkg::*;
#(
    parameter int PH_W  = FINE_W,
    parameter int PRE_BITS = PRE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [1:0]          psel,
    output logic                step_o,
    output logic [PH_W-1:0]     fine_nx_o
);
    localparam logic [PH_W-1:0]     PH_LAST  = '1;
    localparam logic [PRE_BITS-1:0] PRE_MAX  = '1;
    localparam logic [PRE_BITS-1:0] PRE_MID  = PRE_BITS'((1 << PH_W) - 1);

    typedef struct packed {
        logic [PH_W-1:0]     phase;
        logic [PRE_BITS-1:0] pre;
    } tick_st_t;

    tick_st_t st_q, st_d;
    logic [PRE_BITS-1:0] pre_last;
    logic                icyc;
    logic                pre_term;

    always_comb begin
        case (psel_e'(psel))
            PS_DIV1:  pre_last = '0;
            PS_DIV4:  pre_last = PRE_MID;
            default:  pre_last = PRE_MAX;
        endcase
        icyc     = en && (st_q.phase == PH_LAST);
        pre_term = (st_q.pre >= pre_last);
        step_o   = icyc && pre_term;

        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
            if (icyc)
                st_d.pre = pre_term ? '0 : st_q.pre + 1'b1;
        end

        if (psel_e'(psel) == PS_DIV1)
            fine_nx_o = st_d.phase;
        else
            fine_nx_o = st_d.pre[PH_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q == '0));

endmodule

// File: rtl/pwm_period_timer.sv
module pwm_period_timer
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = TMR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step,
    input  logic [CNT_W-1:0] period,
    output logic             wrap_o,
    output logic [CNT_W-1:0] tmr_nx_o
);
    typedef struct packed {
        logic [CNT_W-1:0] tmr;
    } tmr_st_t;

    tmr_st_t st_q, st_d;

    always_comb begin
        wrap_o = step && (st_q.tmr == period);
        st_d   = st_q;
        if (!en)
            st_d.tmr = '0;
        else if (wrap_o)
            st_d.tmr = '0;
        else if (step)
            st_d.tmr = st_q.tmr + 1'b1;
        tmr_nx_o = st_d.tmr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    wrap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (st_q.tmr == '0));

    // R2
    no_step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !step) |=> $stable(st_q.tmr));

endmodule

// File: rtl/pwm_duty_stage.sv
module pwm_duty_stage
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = TMR_W,
    parameter int PH_W  = FINE_W,
    localparam int DW   = CNT_W + PH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wrap,
    input  logic [CNT_W-1:0] tmr_nx,
    input  logic [PH_W-1:0]  fine_nx,
    input  logic [DW-1:0]    duty_in,
    output logic             pwm_o
);
    typedef struct packed {
        logic [DW-1:0] shadow;
        logic          out;
    } duty_st_t;

    duty_st_t st_q, st_d;
    logic     hit;

    always_comb begin
        hit  = ({tmr_nx, fine_nx} == st_q.shadow);
        st_d = st_q;
        if (!en) begin
            st_d.out = 1'b0;
        end else if (wrap) begin
            st_d.shadow = duty_in;
            st_d.out    = (duty_in != '0);
        end else if (hit) begin
            st_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = st_q.out;

    // R3
    shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (st_q.shadow == $past(duty_in)));

    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(st_q.shadow));

    // R5
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && duty_in == '0) |=> !st_q.out);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && duty_in != '0) |=> st_q.out);

endmodule

// File: rtl/pwm_dbuf_gen.sv
module pwm_dbuf_gen
    import pwm_dbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [TMR_W-1:0]  period_i,
    input  logic [TMR_W-1:0]  duty_hi_i,
    input  logic [FINE_W-1:0] duty_lo_i,
    input  logic [1:0]        psel_i,
    output logic              pwm_o
);
    logic              step;
    logic              wrap;
    logic [FINE_W-1:0] fine_nx;
    logic [TMR_W-1:0]  tmr_nx;

    pwm_tick_gen #(.PH_W(FINE_W), .PRE_BITS(PRE_W)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .psel      (psel_i),
        .step_o    (step),
        .fine_nx_o (fine_nx)
    );

    pwm_period_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .step     (step),
        .period   (period_i),
        .wrap_o   (wrap),
        .tmr_nx_o (tmr_nx)
    );

    pwm_duty_stage #(.CNT_W(TMR_W), .PH_W(FINE_W)) u_duty (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .wrap    (wrap),
        .tmr_nx  (tmr_nx),
        .fine_nx (fine_nx),
        .duty_in ({duty_hi_i, duty_lo_i}),
        .pwm_o   (pwm_o)
    );

    // R1
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_o);

    // R3
    rise_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_o) |-> $past(wrap));

endmodule

// File: tb/tb_pwm_dbuf_gen.sv
`timescale 1ns/1ps
module tb_pwm_dbuf_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] period_i = '0;
    logic [7:0] duty_hi_i = '0;
    logic [1:0] duty_lo_i = '0;
    logic [1:0] psel_i = '0;
    logic       pwm_o;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    pwm_dbuf_gen dut (
        .clk(clk), .rst_n(rst_n), .en(en), .period_i(period_i),
        .duty_hi_i(duty_hi_i), .duty_lo_i(duty_lo_i), .psel_i(psel_i),
        .pwm_o(pwm_o)
    );

    localparam int NV = 7;
    localparam int V_PR  [NV] = '{9,  3, 3,  4, 1, 0, 255};
    localparam int V_DT  [NV] = '{13, 0, 20, 6, 5, 1, 1023};
    localparam int V_PS  [NV] = '{0,  0, 0,  1, 2, 0, 0};
    localparam string V_RQ [NV] = '{"R4/R8", "R5", "R6", "R4", "R4", "R2", "R4"};

    function automatic int div_of(input int ps);
        return (ps == 0) ? 1 : (ps == 1) ? 4 : 16;
    endfunction

    function automatic int per_of(input int pr, input int ps);
        return (pr + 1) * 4 * div_of(ps);
    endfunction

    function automatic int exp_high(input int pr, input int dt, input int ps);
        int n, h;
        n = per_of(pr, ps);
        if (dt == 0) return 0;
        if (ps == 0)      h = dt;
        else if (ps == 1) h = dt * 4;
        else              h = (dt >> 2) * 64 + (dt & 3) * 4;
        return (h >= n) ? n : h;
    endfunction

    task automatic check(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic set_duty(input int dt);
        duty_hi_i = 8'(dt >> 2);
        duty_lo_i = 2'(dt & 3);
    endtask

    // Count high samples over n clocks, sampling 1 ns after each edge.
    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_o) hi++;
            @(posedge clk); #1;
        end
    endtask

    task automatic run_vec(input int pr, input int dt, input int ps, input string rq);
        int n, hi;
        @(negedge clk);
        en = 1'b0; period_i = 8'(pr); psel_i = 2'(ps); set_duty(dt);
        @(posedge clk); @(posedge clk); #1;
        check("R1 disabled output", int'(pwm_o), 0);
        @(negedge clk);
        en = 1'b1;
        n = per_of(pr, ps);
        @(posedge clk); #1;
        count_high(n - 1, hi);
        check("R9 first period low", hi, 0);
        count_high(n, hi);
        check(rq, hi, exp_high(pr, dt, ps));
        check("R2 period length", int'(pwm_o), (dt != 0) ? 1 : 0);
    endtask

    initial begin
        int hi, n;
        // reset state
        period_i = 8'd9; set_duty(13);
        repeat (3) @(posedge clk); #1;
        check("R1 reset output", int'(pwm_o), 0);
        rst_n = 1'b1;

        // vector table; the first entry also sees the set/clear collision (R8)
        for (int v = 0; v < NV; v++)
            run_vec(V_PR[v], V_DT[v], V_PS[v], V_RQ[v]);

        // R7: mid-period duty change applies only from the next wrap
        run_vec(9, 13, 0, "R4");
        n = per_of(9, 0);
        // now 1 ns after the wrap edge that opens a fresh period with width 13
        hi = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_o) hi++;
            if (i == 5) begin @(negedge clk); set_duty(30); @(posedge clk); #1; end
            else begin @(posedge clk); #1; end
        end
        check("R7 old width kept", hi, 13);
        count_high(n, hi);
        check("R7 new width applied", hi, 30);

        // R1: reset in mid-run forces output low
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 reset mid-run", int'(pwm_o), 0);
        @(negedge clk); rst_n = 1'b1; en = 1'b0;

        // R5 after reset: shadow cleared, first period after enable low
        @(negedge clk); en = 1'b1; set_duty(0);
        count_high(per_of(9, 0) * 2, hi);
        check("R5 zero width two periods", hi, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule